// File: doc/BRIEF.md
# UART Receive Line-Event Detector

This block is the receive front end of an asynchronous serial channel. It takes the raw serial line together with a sampling enable that pulses sixteen times per bit. It rebuilds each character from mid-bit samples and hands finished characters to a buffer manager through a one-cycle strobe. The line is tracked for idle periods and breaks, characters that match a programmable control code are diverted, and characters that find no empty buffer are reported.

Every notable condition sets a sticky flag in a six-bit event vector. Software clears a flag by writing 1 to it. A mask selects which flags drive the interrupt output. A live idle bit and a hunt-mode indicator are also brought out. In multidrop mode, a dropped character puts the receiver into hunt mode. Hunt mode discards traffic until the line next goes idle.

Event bit positions: bit 0 buffer received, bit 1 busy, bit 2 control character, bit 3 break start, bit 4 break end, bit 5 idle changed.

Top module: `uart_line_event_rx`

## Requirements
- R1: The idle status rises after (DATA_W+2)*OVS consecutive high samples and falls on the first low sample. Each change sets event bit 5.
- R2: A frame with all data bits 0 and a stop bit of 0 is a break. The first break frame of a break sequence sets event bit 3. Further break frames in the same sequence do not set it again. Break frames are never delivered.
- R3: While a break sequence is active, event bit 4 is set once OVS consecutive high samples are seen, and not earlier.
- R4: When ctl_reject is 1 and a frame's data equals ctl_char, the data is stored in ctl_hold and event bit 2 is set. The character is not delivered. When ctl_reject is 0, the same data is delivered normally.
- R5: If buf_avail is 0 when a frame completes, the character is discarded and event bit 1 is set. Later characters are delivered once buf_avail is 1.
- R6: With multidrop at 1, a busy discard sets hunting. While hunting, characters are discarded without events. Hunting clears when the idle status next rises.
- R7: buf_avail is checked only at the mid-stop sample. If it rises at any point before that sample, the character is delivered and no busy event occurs.
- R8: A delivered character with buf_close at 1 sets event bit 0. The bit is set no earlier than the mid-stop sample.
- R9: Bits are sampled at mid-bit, LSB first. A low pulse that is high again at the middle of the start bit is ignored.
- R10: Event bits are sticky and are cleared by writing 1 to evt_clr. A new set wins over a clear in the same cycle.
- R11: irq is 1 exactly when some event bit is 1 and its evt_mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_en | input | 1 | Oversample enable, OVS pulses per bit |
| rxd | input | 1 | Serial receive line |
| multidrop | input | 1 | Enter hunt mode on busy |
| buf_avail | input | 1 | An empty buffer is ready |
| buf_close | input | 1 | Current character closes its buffer |
| ctl_char | input | DATA_W | Control-character compare value |
| ctl_reject | input | 1 | Divert matching characters |
| chr_valid | output | 1 | One-cycle strobe for a delivered character |
| chr_data | output | DATA_W | Delivered character |
| ctl_hold | output | DATA_W | Last diverted control character |
| evt_clr | input | 6 | Write-one-to-clear event bits |
| evt_mask | input | 6 | Interrupt enable per event |
| evt_flags | output | 6 | Sticky event vector |
| irq | output | 1 | Masked OR of events |
| idle_stat | output | 1 | Live idle status |
| hunting | output | 1 | Receiver discarding until idle |

## Verification
The hardest state to reach is the boundary between a break sequence and normal traffic. The receiver resynchronizes after every stop sample, so a long low period produces a chain of back-to-back break frames. Release the line at the wrong moment and the last frame in the chain is a half-built character. The bench holds the line low for just over two frame times, so the third start bit is rejected at its mid-sample. It then checks the break-end flag both before and after one full bit of high samples. Hunt mode is reached by dropping a character in multidrop mode and is left only by a full character time of idle.

// File: rtl/uler_pkg.sv
package uler_pkg;
    parameter int DW = 8;
    localparam int EV_N    = 6;
    localparam int EV_RX   = 0;
    localparam int EV_BSY  = 1;
    localparam int EV_CCR  = 2;
    localparam int EV_BRKS = 3;
    localparam int EV_BRKE = 4;
    localparam int EV_IDL  = 5;

    typedef enum logic [1:0] {RX_HUNT, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          stop;
    } frame_t;

    function automatic logic is_break(frame_t f);
        return (f.data == '0) && !f.stop;
    endfunction
endpackage

// File: rtl/uler_deser.sv
module uler_deser
    import uler_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rxd,
    output logic   frm_done,
    output frame_t frm
);
    localparam int CW = $clog2(OVS);
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] HALF_C = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] FULL_C = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_B = BW'(DW - 1);

    rx_state_e      st;
    logic [CW-1:0]  cnt;
    logic [BW-1:0]  bcnt;
    logic [DW-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= RX_HUNT;
            cnt      <= '0;
            bcnt     <= '0;
            shreg    <= '0;
            frm_done <= 1'b0;
            frm      <= '0;
        end else begin
            frm_done <= 1'b0;
            if (tick) begin
                case (st)
                    RX_HUNT: if (!rxd) begin
                        st  <= RX_START;
                        cnt <= '0;
                    end
                    RX_START: if (cnt == HALF_C) begin
                        cnt  <= '0;
                        bcnt <= '0;
                        st   <= rxd ? RX_HUNT : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                    RX_DATA: if (cnt == FULL_C) begin
                        cnt   <= '0;
                        shreg <= {rxd, shreg[DW-1:1]};
                        if (bcnt == LAST_B) st <= RX_STOP;
                        else bcnt <= bcnt + 1'b1;
                    end else cnt <= cnt + 1'b1;
                    default: if (cnt == FULL_C) begin
                        cnt      <= '0;
                        frm_done <= 1'b1;
                        frm      <= '{data: shreg, stop: rxd};
                        st       <= RX_HUNT;
                    end else cnt <= cnt + 1'b1;
                endcase
            end
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
        (tick && st == RX_START && cnt == HALF_C && rxd) |=> (st == RX_HUNT && !frm_done)); // R9
endmodule

// File: rtl/uler_line.sv
module uler_line
    import uler_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rxd,
    input  logic frm_done,
    input  logic frm_brk,
    output logic idle_q,
    output logic idl_chg,
    output logic brk_start,
    output logic brk_end
);
    localparam int CHAR_TICKS = (DW + 2) * OVS;
    localparam int OW = $clog2(CHAR_TICKS + 1);
    localparam logic [OW-1:0] SAT_C  = OW'(CHAR_TICKS);
    localparam logic [OW-1:0] IDLE_C = OW'(CHAR_TICKS - 1);
    localparam logic [OW-1:0] BIT_C  = OW'(OVS - 1);

    logic [OW-1:0] ones;
    logic          in_brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ones      <= '0;
            idle_q    <= 1'b0;
            in_brk    <= 1'b0;
            idl_chg   <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
        end else begin
            idl_chg   <= 1'b0;
            brk_start <= 1'b0;
            brk_end   <= 1'b0;
            if (tick) begin
                if (rxd) begin
                    if (ones != SAT_C) ones <= ones + 1'b1;
                    if (ones == IDLE_C && !idle_q) begin
                        idle_q  <= 1'b1;
                        idl_chg <= 1'b1;
                    end
                    if (in_brk && ones == BIT_C) begin
                        in_brk  <= 1'b0;
                        brk_end <= 1'b1;
                    end
                end else begin
                    ones <= '0;
                    if (idle_q) begin
                        idle_q  <= 1'b0;
                        idl_chg <= 1'b1;
                    end
                end
            end
            if (frm_done && frm_brk && !in_brk) begin
                in_brk    <= 1'b1;
                brk_start <= 1'b1;
            end
        end
    end

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (rst)
        (tick && !rxd) |=> !idle_q); // R1
    AST_BRKS_LATCH: assert property (@(posedge clk) disable iff (rst)
        brk_start |-> in_brk); // R2
    AST_BRKE_HIGH: assert property (@(posedge clk) disable iff (rst)
        brk_end |-> $past(rxd)); // R3
endmodule

// File: rtl/uler_events.sv
module uler_events #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    assign irq = |(flags & mask);

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flags) & ~$past(clr)) & ~flags) == '0)); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set) & ~flags) == '0)); // R10
endmodule

// File: rtl/uart_line_event_rx.sv
module uart_line_event_rx
    import uler_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            samp_en,
    input  logic            rxd,
    input  logic            multidrop,
    input  logic            buf_avail,
    input  logic            buf_close,
    input  logic [DW-1:0]   ctl_char,
    input  logic            ctl_reject,
    output logic            chr_valid,
    output logic [DW-1:0]   chr_data,
    output logic [DW-1:0]   ctl_hold,
    input  logic [EV_N-1:0] evt_clr,
    input  logic [EV_N-1:0] evt_mask,
    output logic [EV_N-1:0] evt_flags,
    output logic            irq,
    output logic            idle_stat,
    output logic            hunting
);
    logic   frm_done, frm_brk;
    frame_t frm;
    logic   idl_chg, brk_start, brk_end;
    logic   is_ctl, to_buf, take_ctl, deliver, busy;
    logic [EV_N-1:0] ev_set;

    uler_deser #(.OVS(OVS)) u_deser (
        .clk(clk), .rst(rst), .tick(samp_en), .rxd(rxd),
        .frm_done(frm_done), .frm(frm)
    );

    assign frm_brk = is_break(frm);

    uler_line #(.OVS(OVS)) u_line (
        .clk(clk), .rst(rst), .tick(samp_en), .rxd(rxd),
        .frm_done(frm_done), .frm_brk(frm_brk),
        .idle_q(idle_stat), .idl_chg(idl_chg),
        .brk_start(brk_start), .brk_end(brk_end)
    );

    always_comb begin
        is_ctl   = ctl_reject && (frm.data == ctl_char);
        take_ctl = frm_done && !frm_brk && !hunting && is_ctl;
        to_buf   = frm_done && !frm_brk && !hunting && !is_ctl;
        deliver  = to_buf && buf_avail;
        busy     = to_buf && !buf_avail;
        ev_set          = '0;
        ev_set[EV_RX]   = deliver && buf_close;
        ev_set[EV_BSY]  = busy;
        ev_set[EV_CCR]  = take_ctl;
        ev_set[EV_BRKS] = brk_start;
        ev_set[EV_BRKE] = brk_end;
        ev_set[EV_IDL]  = idl_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chr_valid <= 1'b0;
            chr_data  <= '0;
            ctl_hold  <= '0;
            hunting   <= 1'b0;
        end else begin
            chr_valid <= deliver;
            if (deliver)  chr_data <= frm.data;
            if (take_ctl) ctl_hold <= frm.data;
            if (busy && multidrop)          hunting <= 1'b1;
            else if (idl_chg && idle_stat)  hunting <= 1'b0;
        end
    end

    uler_events #(.N(EV_N)) u_events (
        .clk(clk), .rst(rst), .set(ev_set), .clr(evt_clr),
        .mask(evt_mask), .flags(evt_flags), .irq(irq)
    );

    AST_HUNT_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && multidrop) |=> hunting); // R6
    AST_DELIVER_NEEDS_BUF: assert property (@(posedge clk) disable iff (rst)
        chr_valid |-> $past(buf_avail)); // R5
    AST_NO_DELIVER_HUNT: assert property (@(posedge clk) disable iff (rst)
        chr_valid |-> !$past(hunting)); // R6
endmodule

// File: tb/uart_line_event_rx_test.sv
module uart_line_event_rx_test;
    localparam int CLK_P = 10;
    localparam int OVS   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       samp_en = 1'b0;
    logic       rxd = 1'b1;
    logic       multidrop = 1'b0;
    logic       buf_avail = 1'b1;
    logic       buf_close = 1'b0;
    logic [7:0] ctl_char = 8'h00;
    logic       ctl_reject = 1'b0;
    logic       chr_valid;
    logic [7:0] chr_data, ctl_hold;
    logic [5:0] evt_clr = '0;
    logic [5:0] evt_mask = '0;
    logic [5:0] evt_flags;
    logic       irq, idle_stat, hunting;

    int n_chk = 0, n_bad = 0, n_rx = 0, cyc = 0;
    logic [7:0] last_rx = '0;

    uart_line_event_rx #(.OVS(OVS)) uut (
        .clk(clk), .rst(rst), .samp_en(samp_en), .rxd(rxd),
        .multidrop(multidrop), .buf_avail(buf_avail), .buf_close(buf_close),
        .ctl_char(ctl_char), .ctl_reject(ctl_reject),
        .chr_valid(chr_valid), .chr_data(chr_data), .ctl_hold(ctl_hold),
        .evt_clr(evt_clr), .evt_mask(evt_mask), .evt_flags(evt_flags),
        .irq(irq), .idle_stat(idle_stat), .hunting(hunting)
    );

    always #(CLK_P/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        samp_en = ~samp_en;
    end

    always @(negedge clk) begin
        if (chr_valid) begin
            n_rx    <= n_rx + 1;
            last_rx <= chr_data;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold(input int ticks);
        repeat (2 * ticks) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk);
        evt_clr = 6'h3f;
        @(negedge clk);
        evt_clr = 6'h00;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stop, input int avail_bit);
        rxd = 1'b0;
        hold(OVS);
        for (int i = 0; i < 8; i++) begin
            if (i == avail_bit) buf_avail = 1'b1;
            rxd = d[i];
            hold(OVS);
        end
        rxd = stop;
        hold(OVS);
        rxd = 1'b1;
        hold(2);
    endtask

    task automatic t_reset();
        chk("R10 reset flags", evt_flags, 6'h00);
        chk("R11 reset irq", irq, 1'b0);
        chk("R1 reset idle", idle_stat, 1'b0);
        chk("R6 reset hunting", hunting, 1'b0);
    endtask

    task automatic t_idle_and_glitch();
        int base;
        hold(150);
        chk("R1 idle not yet", idle_stat, 1'b0);
        hold(20);
        chk("R1 idle set", idle_stat, 1'b1);
        chk("R1 idle event", evt_flags[5], 1'b1);
        clear_all();
        chk("R10 clear", evt_flags, 6'h00);
        base = n_rx;
        rxd = 1'b0;
        hold(4);
        rxd = 1'b1;
        chk("R1 idle dropped", idle_stat, 1'b0);
        chk("R1 idle drop event", evt_flags[5], 1'b1);
        hold(40);
        chk("R9 glitch ignored", n_rx, base);
        chk("R9 glitch no events", evt_flags & 6'h1f, 6'h00);
    endtask

    task automatic t_bytes();
        clear_all();
        buf_avail = 1'b1;
        buf_close = 1'b0;
        send_frame(8'hA5, 1'b1, -1);
        chk("R9 byte A5", last_rx, 8'hA5);
        chk("R8 no close no event", evt_flags[0], 1'b0);
        buf_close = 1'b1;
        send_frame(8'h3C, 1'b1, -1);
        chk("R9 byte 3C", last_rx, 8'h3C);
        chk("R8 close event", evt_flags[0], 1'b1);
        clear_all();
        rxd = 1'b0;
        hold(OVS);
        for (int i = 0; i < 8; i++) begin
            rxd = 8'h5A >> i;
            hold(OVS);
        end
        rxd = 1'b1;
        hold(5);
        chk("R8 not before mid-stop", evt_flags[0], 1'b0);
        hold(13);
        chk("R8 after mid-stop", evt_flags[0], 1'b1);
        chk("R9 byte 5A", last_rx, 8'h5A);
        buf_close = 1'b0;
    endtask

    task automatic t_busy();
        int base;
        clear_all();
        base = n_rx;
        buf_avail = 1'b0;
        send_frame(8'h11, 1'b1, -1);
        chk("R5 dropped", n_rx, base);
        chk("R5 busy event", evt_flags[1], 1'b1);
        chk("R6 no hunt", hunting, 1'b0);
        evt_mask = 6'h02;
        @(negedge clk);
        chk("R11 irq on", irq, 1'b1);
        evt_mask = 6'h01;
        @(negedge clk);
        chk("R11 irq masked", irq, 1'b0);
        evt_mask = 6'h00;
        buf_avail = 1'b1;
        send_frame(8'h22, 1'b1, -1);
        chk("R5 resume", last_rx, 8'h22);
        clear_all();
        buf_avail = 1'b0;
        send_frame(8'h96, 1'b1, 3);
        chk("R7 late buffer delivered", last_rx, 8'h96);
        chk("R7 no busy", evt_flags[1], 1'b0);
    endtask

    task automatic t_hunt();
        int base;
        clear_all();
        multidrop = 1'b1;
        buf_avail = 1'b0;
        send_frame(8'h33, 1'b1, -1);
        chk("R6 hunt entered", hunting, 1'b1);
        clear_all();
        buf_avail = 1'b1;
        base = n_rx;
        send_frame(8'h44, 1'b1, -1);
        chk("R6 hunt discards", n_rx, base);
        chk("R6 hunt no events", evt_flags & 6'h07, 6'h00);
        hold(170);
        chk("R6 hunt left", hunting, 1'b0);
        send_frame(8'h55, 1'b1, -1);
        chk("R6 after hunt", last_rx, 8'h55);
        multidrop = 1'b0;
    endtask

    task automatic t_ctl();
        int base;
        clear_all();
        ctl_char = 8'h7E;
        ctl_reject = 1'b1;
        base = n_rx;
        send_frame(8'h7E, 1'b1, -1);
        chk("R4 hold", ctl_hold, 8'h7E);
        chk("R4 event", evt_flags[2], 1'b1);
        chk("R4 not delivered", n_rx, base);
        clear_all();
        ctl_reject = 1'b0;
        send_frame(8'h7E, 1'b1, -1);
        chk("R4 reject off delivered", last_rx, 8'h7E);
        chk("R4 reject off no event", evt_flags[2], 1'b0);
    endtask

    task automatic t_break();
        int base;
        clear_all();
        base = n_rx;
        rxd = 1'b0;
        hold(160);
        chk("R2 break start", evt_flags[3], 1'b1);
        clear_all();
        hold(149);
        rxd = 1'b1;
        hold(6);
        chk("R2 single break start", evt_flags[3], 1'b0);
        chk("R3 no early end", evt_flags[4], 1'b0);
        hold(12);
        chk("R3 break end", evt_flags[4], 1'b1);
        chk("R2 break not delivered", n_rx, base);
        evt_clr = 6'h10;
        @(negedge clk);
        evt_clr = 6'h00;
        chk("R10 selective clear", evt_flags[4], 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_idle_and_glitch();
        t_bytes();
        t_busy();
        t_hunt();
        t_ctl();
        t_break();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule